// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. The bus has one cycle per access, with an address, a write enable, write data and registered read data. One 32-bit control register selects one of eight clock-enable taps from a shared prescaler, turns the watchdog on and off, and picks what a timeout does. A timeout can raise a one-cycle interrupt pulse, or it can request a system reset that is held for a fixed number of cycles. While the watchdog is enabled, an internal counter advances on each tick of the selected tap. A timeout occurs when the counter wraps from all ones back to zero.

Every write to the control register must carry an 8-bit key. A write with the right key is applied and also clears the counter, which is how software feeds the watchdog. A write with the wrong key changes nothing in the configuration. Instead it is treated as a violation: it fires the configured action and sets a flag that names the wrong key as the cause. Two read-only status bits record what caused the most recent action, so software can find out why it was interrupted or reset.

Top module: `wdg_guard`

## Requirements
- R1: After the synchronous reset, the interrupt and reset-request outputs are low, the counter is zero, and the control register reads all zero.
- R2: The control register has this read layout: bits 2:0 tap select, bit 3 enable, bit 4 mode, bit 5 timeout cause (read-only), bit 6 wrong-key cause (read-only). All other bits, the key field included, read as zero. Read data appears one cycle after the address is presented. An address other than the control register reads as zero.
- R3: A write to the control register applies bits 4:0 only when bits 15:8 hold 0x47. With any other key the configuration is left unchanged, and the configured action fires two cycles after the write edge, whether or not the watchdog is enabled.
- R4: In mode 0, each action is an interrupt pulse exactly one cycle wide, and the reset request stays low.
- R5: Every action sets the timeout-cause bit. The wrong-key bit becomes 1 when the action came from a bad key and 0 when it came from a counter wrap. Both bits keep their value until the next action or reset.
- R6: Tap select value s picks tick input s. The inputs are ordered by ratio /2, /4, /8, /64, /128, /1024, /2048, /4096. While enabled, the counter advances once per tick and times out every 2^CNT_W ticks, repeating periodically.
- R7: With the enable bit clear, the counter holds and no timeout occurs.
- R8: A write that is accepted clears the counter, so writes made more often than the timeout period prevent any action.
- R9: In mode 1, each action drives the reset request high for exactly RST_HOLD cycles (4 by default), and no interrupt is raised.
- R10: Writes to any address other than the control register have no effect, whatever their key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_taps | input | 8 | Clock-enable taps from the shared prescaler |
| irq_o | output | 1 | Interrupt pulse |
| rst_req_o | output | 1 | System reset request |

## Verification
The bench runs the timeout path with all eight tap selections. For each one it measures the interval between two consecutive interrupts and compares it with 2^CNT_W times that tap's ratio. A wrong mapping or a miscounted wrap shows up as a specific wrong period.

The key check is tried with a good key, with a wrong key while the watchdog is enabled and while it is disabled, and with writes to a foreign address. These cases separate an applied write from a rejected one, and a rejected one from a write that is simply ignored.

Disabled operation, periodic feeding and reset mode are each run long enough to distinguish a held counter from a free-running one, a feed from a missed feed, and a correct hold length from one that is off by one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int KEY_W    = 8;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'h47;

  // field positions within the control word
  localparam int POS_SEL    = 0;
  localparam int POS_EN     = 3;
  localparam int POS_MODE   = 4;
  localparam int POS_CAUSE  = 5;
  localparam int POS_KEYERR = 6;
  localparam int POS_KEY    = 8;

  typedef struct packed {
    logic             mode;   // 1: reset request, 0: interrupt
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel
  import wdg_pkg::*;
(
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [SEL_W-1:0]    sel,
  input  logic                en,
  output logic                tick
);
  logic [NUM_TAPS-1:0] pick;

  // one-hot gating per tap, then OR-reduce
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign pick[g] = taps[g] & (sel == SEL_W'(g));
  end

  assign tick = en & (|pick);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  // a feed on the same edge wins over a wrap
  assign wrap = tick & ~clr & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_action.sv
module wdg_action #(
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic mode,
  output logic irq_o,
  output logic rst_req_o
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [HOLD_W-1:0] hold_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
      hold_left <= '0;
    end else begin
      irq_o <= trig & ~mode;
      if (trig && mode) begin
        rst_req_o <= 1'b1;
        hold_left <= HOLD_W'(RST_HOLD - 1);
      end else if (hold_left != '0) begin
        rst_req_o <= 1'b1;
        hold_left <= hold_left - 1'b1;
      end else begin
        rst_req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  output wdg_cfg_t          cfg,
  output logic              wr_ok,
  output logic              bad_q,
  output logic [DATA_W-1:0] rdata
);
  logic hit;
  logic key_match;
  logic cause_q;
  logic keyerr_q;

  assign hit       = (addr == REG_ADDR);
  assign key_match = (wdata[POS_KEY +: KEY_W] == UNLOCK_KEY);
  assign wr_ok     = we & hit & key_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      bad_q    <= 1'b0;
      cause_q  <= 1'b0;
      keyerr_q <= 1'b0;
      rdata    <= '0;
    end else begin
      bad_q <= we & hit & ~key_match;
      if (wr_ok) begin
        cfg.sel  <= wdata[POS_SEL +: SEL_W];
        cfg.en   <= wdata[POS_EN];
        cfg.mode <= wdata[POS_MODE];
      end
      if (fire) begin
        cause_q  <= 1'b1;
        keyerr_q <= bad_q;
      end
      rdata <= '0;
      if (hit) begin
        rdata[POS_SEL +: SEL_W] <= cfg.sel;
        rdata[POS_EN]           <= cfg.en;
        rdata[POS_MODE]         <= cfg.mode;
        rdata[POS_CAUSE]        <= cause_q;
        rdata[POS_KEYERR]       <= keyerr_q;
      end
    end
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3,
  parameter int                CNT_W    = 20,
  parameter int                RST_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        tick_taps,
  output logic              irq_o,
  output logic              rst_req_o
);
  wdg_cfg_t         cfg;
  logic             wr_ok;
  logic             bad_q;
  logic             tick;
  logic             wrap;
  logic             fire;
  logic [CNT_W-1:0] cnt_w;

  assign fire = wrap | bad_q;

  wdg_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .fire(fire), .cfg(cfg), .wr_ok(wr_ok), .bad_q(bad_q), .rdata(bus_rdata)
  );

  wdg_tick_sel u_tick (
    .taps(tick_taps), .sel(cfg.sel), .en(cfg.en), .tick(tick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(wr_ok), .tick(tick), .cnt_q(cnt_w), .wrap(wrap)
  );

  wdg_action #(.RST_HOLD(RST_HOLD)) u_act (
    .clk(clk), .rst(rst), .trig(fire), .mode(cfg.mode),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3,
  parameter int                CNT_W    = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              en,
  input logic [CNT_W-1:0]  cnt
);
  logic good_wr;
  logic bad_wr;
  assign good_wr = bus_we && bus_addr == REG_ADDR && bus_wdata[15:8] == 8'h47;
  assign bad_wr  = bus_we && bus_addr == REG_ADDR && bus_wdata[15:8] != 8'h47;

  // R8
  feed_clears_chk: assert property (@(posedge clk) disable iff (rst)
    good_wr |=> cnt == '0);

  // R3
  bad_key_fires_chk: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> ##1 (irq_o || rst_req_o));

  // R7
  disabled_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !good_wr) |=> $stable(cnt));

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |=> rst_req_o);

  // R4
  no_dual_start_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && $rose(rst_req_o)));
endmodule

bind wdg_guard wdg_guard_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .rst_req_o(rst_req_o), .en(cfg.en), .cnt(cnt_w)
);

// File: tb/wdg_guard_test.sv
module wdg_guard_test;
  localparam int          ADDR_W   = 4;
  localparam logic [3:0]  REG_ADDR = 4'h3;
  localparam int          CNT_W    = 2;
  localparam int          RST_HOLD = 4;
  localparam int          LIMIT    = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tick_taps = '0;
  logic        irq_o;
  logic        rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int irq_n = 0;
  int rst_rise_n = 0;
  int last_irq = 0;
  int prev_irq = 0;
  logic rst_req_d = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  wdg_guard #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_taps(tick_taps), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic int ratio(input int s);
    case (s)
      0: return 2;    1: return 4;    2: return 8;     3: return 64;
      4: return 128;  5: return 1024; 6: return 2048;  default: return 4096;
    endcase
  endfunction

  // prescaler model and output monitor, away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 8; i++) tick_taps[i] <= ((cyc + 1) % ratio(i)) == 0;
    if (irq_o) begin
      irq_n    <= irq_n + 1;
      prev_irq <= last_irq;
      last_irq <= cyc;
    end
    rst_req_d <= rst_req_o;
    if (rst_req_o && !rst_req_d) rst_rise_n <= rst_rise_n + 1;
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < %0d)", cyc, LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] key, input logic [4:0] cfgv);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = {16'h0, key, 3'b000, cfgv};
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] expect_word(input logic kerr, input logic cause,
                                              input logic mode, input logic en,
                                              input logic [2:0] sel);
    return {25'h0, kerr, cause, mode, en, sel};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int base;
    int run;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 rst_req", rst_req_o, 0);
    rd(REG_ADDR, d);
    check("R1 ctrl word", d, 0);

    // R2 / R3 accepted write readback, key reads zero
    wr(REG_ADDR, 8'h47, 5'b0_0_101);
    rd(REG_ADDR, d);
    check("R2 R3 readback", d, expect_word(0, 0, 0, 0, 3'd5));
    rd(4'h7, d);
    check("R2 foreign read zero", d, 0);

    // R10 foreign address writes ignored
    wr(4'h7, 8'h47, 5'b1_1_010);
    wr(4'h7, 8'h13, 5'b1_1_010);
    idle(4);
    rd(REG_ADDR, d);
    check("R10 config kept", d, expect_word(0, 0, 0, 0, 3'd5));
    check("R10 no irq", irq_n, 0);

    // R3 / R4 / R5 wrong key while disabled, interrupt mode
    base = irq_n;
    @(negedge clk);
    bus_addr = REG_ADDR; bus_we = 1'b1; bus_wdata = {16'h0, 8'h46, 8'h1F};
    @(negedge clk);
    bus_we = 1'b0;
    check("R3 irq not yet", irq_o, 0);
    @(negedge clk);
    check("R3 R4 irq fires", irq_o, 1);
    check("R4 no reset req", rst_req_o, 0);
    @(negedge clk);
    check("R4 one cycle", irq_o, 0);
    rd(REG_ADDR, d);
    check("R3 R5 config kept, key flag", d, expect_word(1, 1, 0, 0, 3'd5));
    check("R4 single pulse", irq_n - base, 1);

    // R6 tap sweep: period between consecutive timeouts
    for (int s = 0; s < 8; s++) begin
      wr(REG_ADDR, 8'h47, {2'b01, 3'(s)});
      base = irq_n;
      while (irq_n < base + 2) @(negedge clk);
      check($sformatf("R6 period sel %0d", s), last_irq - prev_irq, (1 << CNT_W) * ratio(s));
    end
    rd(REG_ADDR, d);
    check("R5 timeout clears key flag", d, expect_word(0, 1, 0, 1, 3'd7));

    // R7 disabled holds
    wr(REG_ADDR, 8'h47, 5'b0_0_000);
    base = irq_n;
    idle(500);
    check("R7 no timeout when disabled", irq_n - base, 0);

    // R8 feeding prevents timeout (period 8 cycles, feed every 4)
    wr(REG_ADDR, 8'h47, 5'b0_1_000);
    base = irq_n;
    for (int i = 0; i < 50; i++) begin
      wr(REG_ADDR, 8'h47, 5'b0_1_000);
      idle(2);
    end
    check("R8 fed watchdog silent", irq_n - base, 0);
    wr(REG_ADDR, 8'h47, 5'b0_0_000);

    // R9 reset mode via timeout
    base = rst_rise_n;
    wr(REG_ADDR, 8'h47, 5'b1_1_000);
    while (!rst_req_o) @(negedge clk);
    wr(REG_ADDR, 8'h47, 5'b1_0_000);
    run = 0;
    // reset request rose at the sample before the write started
    run = 1;
    // two negedges consumed by the write
    run = run + 2;
    while (rst_req_o) begin
      run++;
      @(negedge clk);
    end
    check("R9 hold length", run - 1, RST_HOLD);
    check("R9 one request", rst_rise_n - base, 1);
    base = irq_n;
    idle(20);
    check("R9 no irq in reset mode", irq_n - base, 0);

    // R9 R3 wrong key in reset mode while disabled
    base = rst_rise_n;
    wr(REG_ADDR, 8'h00, 5'b0_0_000);
    @(negedge clk);
    check("R3 R9 reset req fires", rst_req_o, 1);
    idle(RST_HOLD - 1);
    check("R9 still high at end", rst_req_o, 1);
    @(negedge clk);
    check("R9 released", rst_req_o, 0);
    rd(REG_ADDR, d);
    check("R3 R5 reset-mode key fail", d, expect_word(1, 1, 1, 0, 3'd0));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule